// File: doc/BRIEF.md
# Daisy-Chained Release-on-Acknowledge Interrupt Requester

This block is the interrupter side of a backplane module that sits on a prioritized bus with seven interrupt request lines. A one-cycle local event makes it pull down the single request line chosen by a 3-bit configured level. The chosen level is captured when the event occurs. The interrupt handler then starts an acknowledge cycle. It drives the level it is serving in binary on three address lines and asserts the acknowledge input, which reaches this slot through a daisy chain.

When the block is pending on the level being served, it keeps the chain closed and places a status/ID word on the data lines. One cycle later it asserts the data acknowledge. It releases its request as soon as it begins to answer. In every other situation it forwards the acknowledge to the next slot in the same cycle. A second event that arrives while a request is in flight is remembered, and the request is raised again once the current acknowledge cycle ends. All bus lines are active-low open-collector lines. The block therefore presents active-high drive enables for them, and the forwarded acknowledge is an active-low level.

Top module: `irq_chain_requester`

## Requirements
- R1: After reset no request line is driven, `iack_out_n` follows `iack_in_n`, `data_oe_o` and `dtack_oe_o` are 0, and `data_o` is all zeros.
- R2: A pulse on `evt_i` with `cfg_level_i` = L in 1..7 sets, from the next clock edge, only bit L-1 of `irq_drv_o`. An event with level 0 is ignored. At most one bit of `irq_drv_o` is ever set.
- R3: While the block is not pending, or the level on `ack_level_i` differs from its pending level, `iack_out_n` equals `iack_in_n` in the same cycle.
- R4: While the block is pending and `ack_level_i` equals its level, or while it is answering, `iack_out_n` stays 1.
- R5: At the clock edge where a matching acknowledge is accepted, `data_oe_o` rises and `irq_drv_o` returns to zero (release on acknowledge).
- R6: `dtack_oe_o` rises one clock after `data_oe_o` and stays high with it while `iack_in_n` stays 0.
- R7: On the first clock edge that samples `iack_in_n` = 1 during an answer, `data_oe_o` and `dtack_oe_o` drop, and `data_o` becomes zero.
- R8: The status word holds the logical address in bits 7:0 and the cause byte in bits 15:8. Cause select 0 gives 0xFF, 1 gives 0xFD, 2 gives 0xFC, and 3 gives {1, 0, user code[5:0]}. Bits above 15 are zero. The word is sampled in the cycle the acknowledge is accepted.
- R9: An event that arrives while the block is pending or answering makes the request on the same level reappear at the edge where the answer ends.
- R10: An acknowledge cycle that this slot has already forwarded stays forwarded until `iack_in_n` returns to 1, even if a matching request becomes pending during it. That request is answered in the next acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Local event pulse, one cycle |
| cfg_level_i | input | 3 | Configured request level, 0 disables requesting |
| log_addr_i | input | 8 | Logical address of the module |
| cause_sel_i | input | 2 | Cause selector for status bits 15:8 |
| user_code_i | input | 6 | User event code used when cause select is 3 |
| iack_in_n | input | 1 | Incoming daisy-chain acknowledge, active low |
| ack_level_i | input | 3 | Level under acknowledge (address lines 3:1) |
| irq_drv_o | output | 7 | Drive enables for request lines 1..7 (bit k drives line k+1 low) |
| iack_out_n | output | 1 | Outgoing daisy-chain acknowledge, active low |
| data_o | output | 16 | Status/ID word |
| data_oe_o | output | 1 | Data bus drive enable |
| dtack_oe_o | output | 1 | Drive enable that pulls the data acknowledge low |

## Verification
A local event can land in the same cycle as an acknowledge-cycle transition. This happens when the block is answering, when the answer ends, or when the chain is already being forwarded. The bench provokes both of the interesting cases with directed sequences. It pulses the event while data is on the bus, and it also pulses the event, on the level being served, while an acknowledge is being passed on. In the first case it expects the request line back at the very edge where the data enable drops. In the second it expects the chain to stay open and no answer until a fresh acknowledge cycle begins. Random levels, acknowledge levels and status fields exercise the same paths against a bench model.

// File: rtl/irqreq_pkg.sv
package irqreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_DATA = 2'd2,
    ST_ACK  = 2'd3
  } req_state_e;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_TRUE  = 2'd1;
  localparam logic [1:0] CAUSE_FALSE = 2'd2;
  localparam logic [1:0] CAUSE_USER  = 2'd3;

  function automatic logic [7:0] cause_byte(input logic [1:0] sel, input logic [5:0] user);
    case (sel)
      CAUSE_NONE:  cause_byte = 8'hFF;
      CAUSE_TRUE:  cause_byte = 8'hFD;
      CAUSE_FALSE: cause_byte = 8'hFC;
      default:     cause_byte = {2'b10, user};
    endcase
  endfunction

endpackage

// File: rtl/irqreq_fsm.sv
module irqreq_fsm
  import irqreq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [LVL_W-1:0] cfg_level_i,
  input  logic             iack_in_n,
  input  logic [LVL_W-1:0] ack_level_i,
  output logic             pend_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             accept_o,
  output logic             block_o,
  output logic             data_oe_o,
  output logic             dtack_oe_o
);

  req_state_e       st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             again_q, again_d;
  logic             pass_q, pass_d;
  logic             answering, done;

  assign answering = (st_q == ST_DATA) || (st_q == ST_ACK);
  assign accept_o  = (st_q == ST_PEND) && !iack_in_n && !pass_q && (ack_level_i == lvl_q);
  assign block_o   = !pass_q && (((st_q == ST_PEND) && (ack_level_i == lvl_q)) || answering);
  assign done      = answering && iack_in_n;

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    again_d = again_q;
    pass_d  = !iack_in_n && (pass_q || !block_o);
    case (st_q)
      ST_IDLE: if (evt_i && (cfg_level_i != '0)) begin
        st_d  = ST_PEND;
        lvl_d = cfg_level_i;
      end
      ST_PEND: begin
        if (evt_i) again_d = 1'b1;
        if (accept_o) st_d = ST_DATA;
      end
      default: begin
        if (evt_i) again_d = 1'b1;
        if (done) begin
          st_d    = (again_q || evt_i) ? ST_PEND : ST_IDLE;
          again_d = 1'b0;
        end else if (st_q == ST_DATA) begin
          st_d = ST_ACK;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      again_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      lvl_q   <= lvl_d;
      again_q <= again_d;
      pass_q  <= pass_d;
    end
  end

  assign pend_o     = (st_q == ST_PEND);
  assign lvl_o      = lvl_q;
  assign data_oe_o  = answering;
  assign dtack_oe_o = (st_q == ST_ACK);

  // R6
  dtack_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_oe_o) |-> $past(data_oe_o));

  // R7
  answer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_in_n && data_oe_o) |=> !data_oe_o && !dtack_oe_o);

endmodule

// File: rtl/irqreq_status.sv
module irqreq_status
  import irqreq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              drive_i,
  input  logic [LA_W-1:0]   log_addr_i,
  input  logic [1:0]        cause_sel_i,
  input  logic [5:0]        user_code_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_i) word_d = DATA_W'({cause_byte(cause_sel_i, user_code_i), log_addr_i});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign data_o = drive_i ? word_q : '0;

endmodule

// File: rtl/irqreq_line_drv.sv
module irqreq_line_drv #(
  parameter int NUM_LVL = 7,
  parameter int LVL_W   = 3
) (
  input  logic               pend_i,
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic               iack_in_n,
  input  logic               block_i,
  output logic [NUM_LVL-1:0] irq_drv_o,
  output logic               iack_out_n
);

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_line
    assign irq_drv_o[k] = pend_i && (lvl_i == LVL_W'(k + 1));
  end

  assign iack_out_n = iack_in_n || block_i;

endmodule

// File: rtl/irq_chain_requester.sv
module irq_chain_requester #(
  parameter int NUM_LVL = 7,
  parameter int DATA_W  = 16,
  parameter int LA_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       evt_i,
  input  logic [$clog2(NUM_LVL+1)-1:0] cfg_level_i,
  input  logic [LA_W-1:0]            log_addr_i,
  input  logic [1:0]                 cause_sel_i,
  input  logic [5:0]                 user_code_i,
  input  logic                       iack_in_n,
  input  logic [$clog2(NUM_LVL+1)-1:0] ack_level_i,
  output logic [NUM_LVL-1:0]         irq_drv_o,
  output logic                       iack_out_n,
  output logic [DATA_W-1:0]          data_o,
  output logic                       data_oe_o,
  output logic                       dtack_oe_o
);

  localparam int LVL_W = $clog2(NUM_LVL + 1);

  logic             pend, accept, block;
  logic [LVL_W-1:0] lvl;

  irqreq_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg_level_i(cfg_level_i),
    .iack_in_n(iack_in_n), .ack_level_i(ack_level_i),
    .pend_o(pend), .lvl_o(lvl), .accept_o(accept), .block_o(block),
    .data_oe_o(data_oe_o), .dtack_oe_o(dtack_oe_o)
  );

  irqreq_status #(.DATA_W(DATA_W), .LA_W(LA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .drive_i(data_oe_o),
    .log_addr_i(log_addr_i), .cause_sel_i(cause_sel_i), .user_code_i(user_code_i),
    .data_o(data_o)
  );

  irqreq_line_drv #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_line (
    .pend_i(pend), .lvl_i(lvl), .iack_in_n(iack_in_n), .block_i(block),
    .irq_drv_o(irq_drv_o), .iack_out_n(iack_out_n)
  );

  // R2
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_drv_o));

  // R3
  chain_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_out_n |-> !iack_in_n);

  // R4
  no_pass_while_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> iack_out_n);

  // R5
  roak_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> (irq_drv_o == '0));

endmodule

// File: tb/irq_chain_requester_bench.sv
module irq_chain_requester_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0;
  logic [2:0]  cfg_level = 3'd0;
  logic [7:0]  la = 8'h00;
  logic [1:0]  sel = 2'd0;
  logic [5:0]  ucode = 6'd0;
  logic        iack_in_n = 1'b1;
  logic [2:0]  ack_level = 3'd0;
  logic [6:0]  irq_drv;
  logic        iack_out_n;
  logic [15:0] data;
  logic        data_oe, dtack_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irq_chain_requester u_irq_chain_requester (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_level_i(cfg_level),
    .log_addr_i(la), .cause_sel_i(sel), .user_code_i(ucode),
    .iack_in_n(iack_in_n), .ack_level_i(ack_level),
    .irq_drv_o(irq_drv), .iack_out_n(iack_out_n), .data_o(data),
    .data_oe_o(data_oe), .dtack_oe_o(dtack_oe)
  );

  function automatic logic [6:0] onehot(input logic [2:0] lv);
    return (lv == 3'd0) ? 7'd0 : 7'(1 << (lv - 1));
  endfunction

  function automatic logic [15:0] exp_word(input logic [7:0] a, input logic [1:0] s, input logic [5:0] u);
    logic [7:0] c;
    case (s)
      2'd0: c = 8'hFF;
      2'd1: c = 8'hFD;
      2'd2: c = 8'hFC;
      default: c = {1'b1, 1'b0, u};
    endcase
    return {c, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic raise(input logic [2:0] lv);
    cfg_level = lv; evt = 1'b1;
    @(negedge clk); evt = 1'b0;
    chk(irq_drv == onehot(lv), "R2 request line", 32'(irq_drv), 32'(onehot(lv)));
  endtask

  task automatic ack_cycle(input logic [2:0] al, input bit serve, input logic [15:0] exp);
    ack_level = al; iack_in_n = 1'b0; #1;
    if (serve) chk(iack_out_n == 1'b1, "R4 chain blocked", 32'(iack_out_n), 32'd1);
    else       chk(iack_out_n == 1'b0, "R3 chain forwarded", 32'(iack_out_n), 32'd0);
    @(negedge clk);
    if (serve) begin
      chk(data_oe && !dtack_oe, "R5 data before dtack", {30'd0, data_oe, dtack_oe}, 32'd2);
      chk(irq_drv == 7'd0, "R5 request released", 32'(irq_drv), 32'd0);
      chk(data == exp, "R8 status word", 32'(data), 32'(exp));
      chk(iack_out_n == 1'b1, "R4 chain held", 32'(iack_out_n), 32'd1);
    end else begin
      chk(!data_oe && !iack_out_n, "R3 no answer", {30'd0, data_oe, iack_out_n}, 32'd0);
    end
    @(negedge clk);
    if (serve) chk(data_oe && dtack_oe, "R6 dtack held", {30'd0, data_oe, dtack_oe}, 32'd3);
    iack_in_n = 1'b1;
    @(negedge clk);
    chk(!data_oe && !dtack_oe && data == 16'd0, "R7 bus released",
        {14'd0, data_oe, dtack_oe, data}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq_drv == 7'd0 && !data_oe && !dtack_oe && data == 16'd0 && iack_out_n,
        "R1 reset state", {irq_drv, data_oe, dtack_oe, iack_out_n, data}, 32'h0001_0000);

    // R2 level 0 ignored
    cfg_level = 3'd0; evt = 1'b1; @(negedge clk); evt = 1'b0;
    chk(irq_drv == 7'd0, "R2 level zero ignored", 32'(irq_drv), 32'd0);
    // R3 idle slot forwards
    ack_cycle(3'd7, 1'b0, 16'd0);

    // directed: level 7, cause none
    la = 8'h2A; sel = 2'd0;
    raise(3'd7);
    ack_cycle(3'd7, 1'b1, exp_word(8'h2A, 2'd0, 6'd0));

    // R8 user code; config change after event does not move the line
    la = 8'h01; sel = 2'd3; ucode = 6'h15;
    raise(3'd1);
    cfg_level = 3'd6; @(negedge clk);
    chk(irq_drv == 7'b0000001, "R2 level captured", 32'(irq_drv), 32'd1);
    ack_cycle(3'd6, 1'b0, 16'd0);
    chk(irq_drv == 7'b0000001, "R3 still pending after pass", 32'(irq_drv), 32'd1);
    ack_cycle(3'd1, 1'b1, exp_word(8'h01, 2'd3, 6'h15));

    // R9 second event during answer
    la = 8'h80; sel = 2'd1;
    raise(3'd4);
    ack_level = 3'd4; iack_in_n = 1'b0;
    @(negedge clk);
    chk(data_oe && data == exp_word(8'h80, 2'd1, 6'd0), "R9 answering",
        {15'd0, data_oe, data}, {15'd0, 1'b1, exp_word(8'h80, 2'd1, 6'd0)});
    evt = 1'b1; @(negedge clk); evt = 1'b0;
    iack_in_n = 1'b1; @(negedge clk);
    chk(!data_oe && irq_drv == onehot(3'd4), "R9 request reappears",
        {24'd0, data_oe, irq_drv}, 32'(onehot(3'd4)));
    sel = 2'd2;
    ack_cycle(3'd4, 1'b1, exp_word(8'h80, 2'd2, 6'd0));
    chk(irq_drv == 7'd0, "R9 no third request", 32'(irq_drv), 32'd0);

    // R10 event on served level while chain already forwarded
    ack_level = 3'd3; iack_in_n = 1'b0; @(negedge clk);
    cfg_level = 3'd3; evt = 1'b1; @(negedge clk); evt = 1'b0;
    chk(irq_drv == onehot(3'd3) && !iack_out_n, "R10 chain stays open",
        {24'd0, iack_out_n, irq_drv}, 32'(onehot(3'd3)));
    @(negedge clk);
    chk(!data_oe && !iack_out_n, "R10 no answer mid cycle", {30'd0, data_oe, iack_out_n}, 32'd0);
    iack_in_n = 1'b1; @(negedge clk);
    la = 8'h33; sel = 2'd0;
    ack_cycle(3'd3, 1'b1, exp_word(8'h33, 2'd0, 6'd0));

    // R7 early release right after acceptance
    raise(3'd2);
    ack_level = 3'd2; iack_in_n = 1'b0; @(negedge clk);
    iack_in_n = 1'b1; @(negedge clk);
    chk(!data_oe && !dtack_oe && irq_drv == 7'd0, "R7 early release",
        {23'd0, data_oe, dtack_oe, irq_drv}, 32'd0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [2:0] lv, al;
      lv = 3'(1 + ($urandom % 7));
      al = 3'($urandom % 8);
      la = 8'($urandom); sel = 2'($urandom); ucode = 6'($urandom);
      raise(lv);
      if (al != lv) ack_cycle(al, 1'b0, 16'd0);
      ack_cycle(lv, 1'b1, exp_word(la, sel, ucode));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule